// File: doc/BRIEF.md
# Word-to-Byte Dual-Clock FIFO

This block carries data between two clock domains that have no phase or frequency relationship. A producer pushes 32-bit words on the write clock. A consumer pulls 8-bit bytes on the read clock. Every stored word leaves as four consecutive bytes, lowest byte first. The block therefore doubles as a clock-domain crossing and as a 4:1 width down-converter.

Pointer positions cross the domain boundary as Gray code through two-flop synchronisers. The write side computes its fill level and its full flag from its own pointer and the synchronised read pointer. The read side computes empty from its own pointer and the synchronised write pointer. One word slot is always left unused, so a full buffer never looks the same as an empty one. Bad accesses are never applied. A write into a buffer with no free slot, or a read from an empty buffer, leaves the pointers unchanged and raises a one-cycle flag in the requesting domain.

The read side works in first-word-fall-through style. While the buffer is not empty, the byte at the head of the queue is already on the read data port. A read strobe consumes that byte.

Top module: `byte_unpack_fifo`

## Requirements
- R1: While reset is low, and after it is released, rdEmpty is 1 and wrFull, wrOverflow and rdUnderflow are 0. A reset in the middle of traffic discards all stored data.
- R2: Each stored word appears on rdData as four bytes in order: bits 7:0 first, then 15:8, 23:16 and 31:24. Whenever rdEmpty is 0, rdData shows the byte at the head of the queue, and a read strobe moves to the next byte.
- R3: Words leave the buffer in the order in which they were accepted.
- R4: With the depth set to N words (2048 by default), wrFull is 1 while the write side sees at least N-2 words stored. Exactly one further write is still accepted and wrFull stays 1 after it. wrFull returns to 0 once the reader has drained the buffer and the write side has seen that.
- R5: A write attempted while the write side sees N-1 words stored is rejected. The write pointer does not move, the word is never read out, and wrOverflow is 1 for the write-clock cycle after the attempt.
- R6: rdEmpty only changes at whole-word boundaries. It stays 0 until all four bytes of the last visible word have been read, and goes to 1 on the read edge that consumes the fourth byte.
- R7: A read strobe while rdEmpty is 1 leaves the read position unchanged and sets rdUnderflow to 1 for the following read-clock cycle. Data written afterwards is still read from its first byte.
- R8: Both pointers cross domains as Gray code, changing one bit per step, through two-flop synchronisers. A word written on the write clock becomes visible to the reader within four read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock, unrelated to wrClk |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| wrEn | input | 1 | Write request for wrData |
| wrData | input | 32 | Word to store |
| wrFull | output | 1 | Buffer at or beyond N-2 words, as seen by the write side |
| wrOverflow | output | 1 | One-cycle pulse: the previous write was dropped |
| rdEn | input | 1 | Consume the byte on rdData |
| rdData | output | 8 | Byte at the head of the queue |
| rdEmpty | output | 1 | No complete word visible to the read side |
| rdUnderflow | output | 1 | One-cycle pulse: the previous read found the buffer empty |

## Verification
The bench fills the buffer to its exact limit with the reader stopped. It checks that full rises on the (N-2)th word and not before, that one more word is accepted, and that the next word raises overflow and never comes out. A design with full one slot off, or one that stores the dropped word, fails those checks. A table of words with distinct bytes catches a swapped byte order or a lost word. Reading a single word byte by byte catches empty going high in the middle of a word. A read on an empty buffer that moved the pointer shows up as a shifted byte on the next word written.

// File: rtl/byte_unpack_fifo_pkg.sv
package byte_unpack_fifo_pkg;
  // number of read lanes packed into one write word
  localparam int LANES     = 4;
  localparam int LANE_BITS = $clog2(LANES);

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic                 wrStrobe;   // commit wrData into the current write slot
    logic [LANE_BITS-1:0] laneSel;    // which byte of the head word is presented
  } fifo_strobe_t;
endpackage

// File: rtl/bu_sync2.sv
module bu_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/bu_ctrl.sv
module bu_ctrl
  import byte_unpack_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic         wrClk,
  input  logic         rdClk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  output logic         wrFull,
  output logic         wrOverflow,
  output logic         rdEmpty,
  output logic         rdUnderflow,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output fifo_strobe_t strobes
);
  localparam int PW = AW + 1;          // word pointer with wrap bit
  localparam int BW = PW + LANE_BITS;  // byte pointer

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtrBin, wrPtrGray, wrPtrNext;
  logic [PW-1:0] rdGraySync, rdSyncBin, wrCount;
  logic          wrRoom, wrAccept;

  assign rdSyncBin = grayToBin(rdGraySync);
  assign wrCount   = wrPtrBin - rdSyncBin;
  assign wrRoom    = wrCount < PW'(DEPTH - 1);
  assign wrAccept  = wrEn && wrRoom;
  assign wrFull    = wrCount >= PW'(DEPTH - 2);
  assign wrPtrNext = wrPtrBin + 1'b1;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtrBin   <= '0;
      wrPtrGray  <= '0;
      wrOverflow <= 1'b0;
    end else begin
      wrOverflow <= wrEn && !wrRoom;
      if (wrAccept) begin
        wrPtrBin  <= wrPtrNext;
        wrPtrGray <= wrPtrNext ^ (wrPtrNext >> 1);
      end
    end
  end

  // ---------------- read domain ----------------
  logic [BW-1:0] rdBytePtr, rdByteNext;
  logic [PW-1:0] rdWordBin, rdWordNext, rdWordGray;
  logic [PW-1:0] wrGraySync, wrSyncBin;
  logic          rdAccept;

  assign rdWordBin  = rdBytePtr[BW-1:LANE_BITS];
  assign rdByteNext = rdBytePtr + 1'b1;
  assign rdWordNext = rdByteNext[BW-1:LANE_BITS];
  assign wrSyncBin  = grayToBin(wrGraySync);
  assign rdEmpty    = (wrSyncBin == rdWordBin);
  assign rdAccept   = rdEn && !rdEmpty;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBytePtr   <= '0;
      rdWordGray  <= '0;
      rdUnderflow <= 1'b0;
    end else begin
      rdUnderflow <= rdEn && rdEmpty;
      if (rdAccept) begin
        rdBytePtr  <= rdByteNext;
        rdWordGray <= rdWordNext ^ (rdWordNext >> 1);
      end
    end
  end

  // ---------------- crossings ----------------
  bu_sync2 #(.W(PW)) i_rdToWr (.clk(wrClk), .rstN(rstN), .din(rdWordGray), .dout(rdGraySync));
  bu_sync2 #(.W(PW)) i_wrToRd (.clk(rdClk), .rstN(rstN), .din(wrPtrGray),  .dout(wrGraySync));

  assign wrAddr           = wrPtrBin[AW-1:0];
  assign rdAddr           = rdWordBin[AW-1:0];
  assign strobes.wrStrobe = wrAccept;
  assign strobes.laneSel  = rdBytePtr[LANE_BITS-1:0];

  // ---------------- assertions ----------------
  AST_WR_PTR_SINGLE_STEP: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrPtrBin - $past(wrPtrBin)) <= PW'(1));  // R4
  AST_NO_OVERFLOW_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && !wrRoom) |=> (wrOverflow && $stable(wrPtrBin)));  // R5
  AST_EMPTY_WORD_ALIGNED: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEmpty |-> (rdBytePtr[LANE_BITS-1:0] == '0));  // R6
  AST_NO_UNDERFLOW_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && rdEmpty) |=> (rdUnderflow && $stable(rdBytePtr)));  // R7
  AST_WR_GRAY_ONE_BIT: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrPtrGray ^ $past(wrPtrGray)) <= 1);  // R8
  AST_RD_GRAY_ONE_BIT: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdWordGray ^ $past(rdWordGray)) <= 1);  // R8
endmodule

// File: rtl/bu_datapath.sv
module bu_datapath
  import byte_unpack_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int RD_W  = 8
) (
  input  logic                  wrClk,
  input  logic [RD_W*LANES-1:0] wrData,
  input  logic [AW-1:0]         wrAddr,
  input  logic [AW-1:0]         rdAddr,
  input  fifo_strobe_t          strobes,
  output logic [RD_W-1:0]       rdData
);
  localparam int WR_W = RD_W * LANES;

  logic [WR_W-1:0] store [DEPTH];
  logic [WR_W-1:0] headWord;
  logic [RD_W-1:0] lanes [LANES];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) store[wrAddr] <= wrData;
  end

  assign headWord = store[rdAddr];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lanes[g] = headWord[g*RD_W +: RD_W];
  end

  assign rdData = lanes[strobes.laneSel];
endmodule

// File: rtl/byte_unpack_fifo.sv
module byte_unpack_fifo
  import byte_unpack_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int RD_W  = 8
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [RD_W*LANES-1:0] wrData,
  output logic                  wrFull,
  output logic                  wrOverflow,
  input  logic                  rdEn,
  output logic [RD_W-1:0]       rdData,
  output logic                  rdEmpty,
  output logic                  rdUnderflow
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wrAddr, rdAddr;
  fifo_strobe_t  strobes;

  bu_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wrFull(wrFull), .wrOverflow(wrOverflow), .rdEmpty(rdEmpty),
    .rdUnderflow(rdUnderflow), .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes)
  );

  bu_datapath #(.DEPTH(DEPTH), .AW(AW), .RD_W(RD_W)) i_datapath (
    .wrClk(wrClk), .wrData(wrData), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strobes(strobes), .rdData(rdData)
  );
endmodule

// File: tb/test_byte_unpack_fifo.sv
module test_byte_unpack_fifo;
  localparam int DEPTH = 2048;
  localparam int NVEC  = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h04030201, 32'hDDCCBBAA, 32'h00FF00FF, 32'h80402010,
    32'h12345678, 32'hF0E1D2C3
  };

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic wrFull, wrOverflow, rdEmpty, rdUnderflow;
  logic [7:0] rdData;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 wrClk = ~wrClk;
  always #6.5 rdClk = ~rdClk;

  byte_unpack_fifo #(.DEPTH(DEPTH), .RD_W(8)) i_byte_unpack_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrOverflow(wrOverflow), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdUnderflow(rdUnderflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [31:0] d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] b);
    int n = 0;
    @(negedge rdClk);
    while (rdEmpty && n < 50) begin @(negedge rdClk); n++; end
    b = rdData;
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    logic [7:0] b;
    int lat;
    // R1: state during and after reset
    #3;
    check("R1 empty in reset", 32'(rdEmpty), 1);
    check("R1 full in reset", 32'(wrFull), 0);
    #40 rstN = 1'b1;
    repeat (3) @(negedge wrClk);
    check("R1 empty after reset", 32'(rdEmpty), 1);
    check("R1 full after reset", 32'(wrFull), 0);
    check("R1 overflow after reset", 32'(wrOverflow), 0);
    check("R1 underflow after reset", 32'(rdUnderflow), 0);

    // R2 / R3: table of words, read back byte by byte
    for (int i = 0; i < NVEC; i++) writeWord(VEC[i]);
    for (int i = 0; i < NVEC; i++)
      for (int l = 0; l < 4; l++) begin
        readByte(b);
        check(l == 0 ? "R3 word order" : "R2 byte order", 32'(b), 32'((VEC[i] >> (8*l)) & 32'hFF));
      end
    @(negedge rdClk);
    check("R6 empty after table drained", 32'(rdEmpty), 1);

    // R7: read while empty
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    check("R7 underflow pulse", 32'(rdUnderflow), 1);
    @(negedge rdClk);
    check("R7 underflow clears", 32'(rdUnderflow), 0);

    // R8: visibility latency; R7: pointer unchanged (first byte intact)
    writeWord(32'h44332211);
    lat = 0;
    while (rdEmpty && lat < 10) begin @(negedge rdClk); lat++; end
    check("R8 word visible within 4 read cycles", 32'(lat <= 4), 1);
    // R6: partial word keeps empty low
    for (int l = 0; l < 3; l++) begin
      readByte(b);
      check(l == 0 ? "R7 first byte after underflow" : "R2 byte of single word", 32'(b), 32'(8'h11 * (l + 1)));
      check("R6 empty low mid-word", 32'(rdEmpty), 0);
    end
    readByte(b);
    check("R2 last byte", 32'(b), 32'h44);
    check("R6 empty after fourth byte", 32'(rdEmpty), 1);

    // R4 / R5: fill to the limit with the reader idle
    repeat (10) @(negedge wrClk);
    for (int i = 0; i < DEPTH - 3; i++) writeWord(32'h5A000000 | 32'(i));
    check("R4 not full at N-3", 32'(wrFull), 0);
    writeWord(32'h5A000000 | 32'(DEPTH - 3));
    check("R4 full at N-2", 32'(wrFull), 1);
    check("R5 no overflow at N-2", 32'(wrOverflow), 0);
    writeWord(32'h5A000000 | 32'(DEPTH - 2));
    check("R4 extra write accepted, still full", 32'(wrFull), 1);
    check("R4 extra write no overflow", 32'(wrOverflow), 0);
    writeWord(32'hDEADBEEF);
    check("R5 overflow pulse", 32'(wrOverflow), 1);
    check("R5 full held", 32'(wrFull), 1);
    @(negedge wrClk);
    check("R5 overflow clears", 32'(wrOverflow), 0);
    for (int i = 0; i < DEPTH - 1; i++)
      for (int l = 0; l < 4; l++) begin
        readByte(b);
        check("R3 fill data", 32'(b), 32'(((32'h5A000000 | 32'(i)) >> (8*l)) & 32'hFF));
      end
    repeat (6) @(negedge rdClk);
    check("R5 dropped word never read", 32'(rdEmpty), 1);
    repeat (6) @(negedge wrClk);
    check("R4 full released after drain", 32'(wrFull), 0);

    // R1: reset mid-traffic discards data
    writeWord(32'hCAFEF00D);
    repeat (6) @(negedge rdClk);
    check("R1 data present before reset", 32'(rdEmpty), 0);
    rstN = 1'b0;
    #20;
    check("R1 empty during reset", 32'(rdEmpty), 1);
    rstN = 1'b1;
    repeat (6) @(negedge rdClk);
    check("R1 empty after second reset", 32'(rdEmpty), 1);
    check("R1 not full after second reset", 32'(wrFull), 0);

    finished = 1;
    finish();
  end
endmodule